// File: doc/BRIEF.md
# Raster Video to Serial Audio-Style Link Serializer

This block turns a stream of raster pixels into a three-wire serial stream shaped like an I2S audio link: a bit clock, a word-select line and one data line. A microcontroller with an I2S receiver can then capture whole video frames on a single data pin. The block runs from a master clock that the receiver supplies. It divides that clock to make the bit clock and shifts each pixel out as one word, most significant bit first. Successive pixels alternate between the left and the right slot.

Pixels arrive in the master-clock domain over a valid/ready handshake. Each beat carries a start-of-frame flag and a blanking flag. Blanking beats are accepted and dropped at once. While no visible pixel is waiting to be shifted, the bit clock stays low and makes no edges, so the receiver only ever clocks in image data.

The receiver raises a clear-to-send line when it can take a new frame. The block samples a synchronized copy of that line only on the first visible pixel of a frame. If the line is high there, the block streams that whole frame. If it is low, the block drops the frame.

Top module: `vid_i2s_serializer`

## Requirements
- R1: While a word is being shifted, the bit clock `sck_o` has a period of exactly DIV master-clock cycles. It is high for the second half of each period.
- R2: Each visible pixel is sent as one word of 3*COMP_W bits on `sd_o`, most significant bit first, one bit per bit-clock period. The word is `pix_data_i` unchanged: red in the top COMP_W bits, green in the middle, blue in the low bits.
- R3: `ws_o` is 0 for a left-slot word and 1 for a right-slot word. Slots alternate with each streamed pixel. The first visible pixel of every streamed frame goes in the left slot, whatever slot the previous frame ended in. `ws_o` takes its new value together with the first bit of the word.
- R4: `sd_o` and `ws_o` change only while `sck_o` is low. They are stable for the whole high phase, in which the receiver samples on the rising edge.
- R5: When no word is waiting (during blanking, while idle, or when starved), `sck_o` stays low with no edges. Over a run, the number of rising edges equals 3*COMP_W times the number of pixels streamed.
- R6: `cts_i` passes through a synchronizer. A frame is streamed only if the synchronized clear-to-send is high at the start-of-frame beat. A frame whose start sees it low produces no bit-clock edges.
- R7: If clear-to-send falls in the middle of a frame, every remaining visible pixel of that frame is still streamed. The next start-of-frame beat that sees clear-to-send low stops streaming, and its pixels are dropped.
- R8: A beat is taken only when `pix_valid_i` and `pix_ready_o` are both high. `pix_ready_o` is high whenever `pix_blank_i` is high. Visible pixels of a streamed frame are neither lost nor reordered.
- R9: After synchronous reset, `sck_o`, `ws_o` and `sd_o` are low, `pix_ready_o` is high and no frame is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | Master clock from the receiver; clocks all logic |
| rst_i | input | 1 | Synchronous reset, active high |
| cts_i | input | 1 | Clear-to-send from the receiver (asynchronous) |
| pix_valid_i | input | 1 | Pixel beat valid |
| pix_ready_o | output | 1 | Pixel beat accepted when high together with valid |
| pix_data_i | input | 3*COMP_W | Pixel as {red, green, blue} |
| pix_sof_i | input | 1 | Beat is the first visible pixel of a frame |
| pix_blank_i | input | 1 | Beat lies in horizontal or vertical blanking |
| sck_o | output | 1 | Gated bit clock |
| ws_o | output | 1 | Word select, 0 left, 1 right |
| sd_o | output | 1 | Serial pixel data |

## Verification
The bench builds the block with COMP_W=2 and DIV=4. That makes 6-bit words and a 4-cycle bit clock, so a single frame sweeps every one of the 64 possible pixel codes and checks each against the arithmetic value. The short word also makes long blanking runs cheap. The shifter drains fully during them, so the bench sees many stop-and-restart points of the bit clock. Frames with odd pixel counts, a clear-to-send drop mid-frame and a frame refused at its start all fit in a few thousand cycles.

// File: rtl/vid_i2s_pkg.sv
package vid_i2s_pkg;

    typedef enum logic {
        GATE_IDLE   = 1'b0,
        GATE_STREAM = 1'b1
    } gate_state_e;

    typedef enum logic {
        SLOT_LEFT  = 1'b0,
        SLOT_RIGHT = 1'b1
    } slot_e;

    function automatic int word_bits(input int comp_w);
        return 3 * comp_w;
    endfunction

    function automatic slot_e other_slot(input slot_e s);
        return (s == SLOT_LEFT) ? SLOT_RIGHT : SLOT_LEFT;
    endfunction

endpackage

// File: rtl/vid_i2s_sync.sv
module vid_i2s_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    generate
        if (STAGES <= 1) begin : g_single
            logic stage_q;
            always_ff @(posedge clk_i) begin
                if (rst_i) stage_q <= 1'b0;
                else       stage_q <= d_i;
            end
            assign q_o = stage_q;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk_i) begin
                if (rst_i) chain_q <= '0;
                else       chain_q <= {chain_q[STAGES-2:0], d_i};
            end
            assign q_o = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/vid_i2s_frame_gate.sv
module vid_i2s_frame_gate
    import vid_i2s_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cts_s_i,
    input  logic              pix_valid_i,
    output logic              pix_ready_o,
    input  logic [WORD_W-1:0] pix_data_i,
    input  logic              pix_sof_i,
    input  logic              pix_blank_i,
    input  logic              take_i,
    output logic              full_o,
    output logic [WORD_W-1:0] word_o,
    output slot_e             slot_o
);
    gate_state_e       state_q;
    logic              full_q;
    logic [WORD_W-1:0] data_q;
    slot_e             slot_q;
    slot_e             next_slot_q;

    logic fire, visible, start, refuse, write;

    assign pix_ready_o = !full_q || pix_blank_i;
    assign fire        = pix_valid_i && pix_ready_o;
    assign visible     = fire && !pix_blank_i;
    assign start       = visible && pix_sof_i && cts_s_i;
    assign refuse      = visible && pix_sof_i && !cts_s_i;
    assign write       = start || (visible && !pix_sof_i && state_q == GATE_STREAM);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q     <= GATE_IDLE;
            full_q      <= 1'b0;
            data_q      <= '0;
            slot_q      <= SLOT_LEFT;
            next_slot_q <= SLOT_LEFT;
        end else begin
            if (start)       state_q <= GATE_STREAM;
            else if (refuse) state_q <= GATE_IDLE;

            if (write) begin
                full_q      <= 1'b1;
                data_q      <= pix_data_i;
                slot_q      <= start ? SLOT_LEFT : next_slot_q;
                next_slot_q <= start ? SLOT_RIGHT : other_slot(next_slot_q);
            end else if (take_i) begin
                full_q <= 1'b0;
            end
        end
    end

    assign full_o = full_q;
    assign word_o = data_q;
    assign slot_o = slot_q;

    // R8: a buffered pixel stays put until the shifter takes it
    p_hold_until_taken_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (full_q && !take_i) |=> (full_q && $stable(data_q) && $stable(slot_q)));

    // R8: blanking beats never stall
    p_blank_ready_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        pix_blank_i |-> pix_ready_o);
endmodule

// File: rtl/vid_i2s_shifter.sv
module vid_i2s_shifter
    import vid_i2s_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int DIV    = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              have_word_i,
    input  logic [WORD_W-1:0] word_i,
    input  slot_e             slot_i,
    output logic              take_o,
    output logic              sck_o,
    output logic              ws_o,
    output logic              sd_o
);
    localparam int HALF  = DIV / 2;
    localparam int PH_W  = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    logic              run_q;
    logic [PH_W-1:0]   ph_q;
    logic [BIT_W-1:0]  bit_q;
    logic [WORD_W-1:0] sh_q;
    logic              ws_q;
    logic              sck_q;

    logic last_ph, last_bit, boundary;

    assign last_ph  = (ph_q == PH_W'(DIV - 1));
    assign last_bit = (bit_q == BIT_W'(WORD_W - 1));
    assign boundary = !run_q || (last_ph && last_bit);
    assign take_o   = have_word_i && boundary;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            run_q <= 1'b0;
            ph_q  <= '0;
            bit_q <= '0;
            sh_q  <= '0;
            ws_q  <= 1'b0;
            sck_q <= 1'b0;
        end else begin
            sck_q <= run_q && !take_o && !last_ph && (int'(ph_q) + 1 >= HALF);
            if (take_o) begin
                run_q <= 1'b1;
                ph_q  <= '0;
                bit_q <= '0;
                sh_q  <= word_i;
                ws_q  <= slot_i;
            end else if (run_q) begin
                if (last_ph) begin
                    ph_q <= '0;
                    if (last_bit) begin
                        run_q <= 1'b0;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                        sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
                    end
                end else begin
                    ph_q <= ph_q + 1'b1;
                end
            end
        end
    end

    assign sck_o = sck_q;
    assign ws_o  = ws_q;
    assign sd_o  = sh_q[WORD_W-1];

    // R4: data and word select hold while the bit clock is high
    p_stable_high_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (sck_q && $past(sck_q)) |-> ($stable(sh_q[WORD_W-1]) && $stable(ws_q)));

    // R3: word select moves only with the first bit of a word
    p_ws_first_bit_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_q && !$stable(ws_q)) |-> (bit_q == '0 && ph_q == '0));

    // R1: bit clock rises at mid-period
    p_period_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(sck_q) |-> (run_q && ph_q == PH_W'(HALF)));

    // R5: no running shifter means a quiet clock
    p_quiet_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(run_q) |-> !sck_q);
endmodule

// File: rtl/vid_i2s_serializer.sv
module vid_i2s_serializer
    import vid_i2s_pkg::*;
#(
    parameter int COMP_W      = 8,
    parameter int DIV         = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  mclk_i,
    input  logic                  rst_i,
    input  logic                  cts_i,
    input  logic                  pix_valid_i,
    output logic                  pix_ready_o,
    input  logic [3*COMP_W-1:0]   pix_data_i,
    input  logic                  pix_sof_i,
    input  logic                  pix_blank_i,
    output logic                  sck_o,
    output logic                  ws_o,
    output logic                  sd_o
);
    localparam int WORD_W = word_bits(COMP_W);

    logic              cts_s;
    logic              take;
    logic              full;
    logic [WORD_W-1:0] word;
    slot_e             slot;

    vid_i2s_sync #(.STAGES(SYNC_STAGES)) u_cts_sync (
        .clk_i (mclk_i),
        .rst_i (rst_i),
        .d_i   (cts_i),
        .q_o   (cts_s)
    );

    vid_i2s_frame_gate #(.WORD_W(WORD_W)) u_gate (
        .clk_i       (mclk_i),
        .rst_i       (rst_i),
        .cts_s_i     (cts_s),
        .pix_valid_i (pix_valid_i),
        .pix_ready_o (pix_ready_o),
        .pix_data_i  (pix_data_i),
        .pix_sof_i   (pix_sof_i),
        .pix_blank_i (pix_blank_i),
        .take_i      (take),
        .full_o      (full),
        .word_o      (word),
        .slot_o      (slot)
    );

    vid_i2s_shifter #(.WORD_W(WORD_W), .DIV(DIV)) u_shift (
        .clk_i       (mclk_i),
        .rst_i       (rst_i),
        .have_word_i (full),
        .word_i      (word),
        .slot_i      (slot),
        .take_o      (take),
        .sck_o       (sck_o),
        .ws_o        (ws_o),
        .sd_o        (sd_o)
    );

    // R9: first cycle out of reset is quiet
    p_reset_quiet_r9: assert property (@(posedge mclk_i) disable iff (rst_i)
        $past(rst_i) |-> (!sck_o && !ws_o && !sd_o && pix_ready_o));
endmodule

// File: tb/test_vid_i2s_serializer.sv
module test_vid_i2s_serializer;
    localparam int COMP_W = 2;
    localparam int DIV    = 4;
    localparam int W      = 3 * COMP_W;

    logic         mclk = 1'b0;
    logic         rst  = 1'b1;
    logic         cts  = 1'b0;
    logic         pix_valid = 1'b0;
    logic         pix_ready;
    logic [W-1:0] pix_data = '0;
    logic         pix_sof = 1'b0;
    logic         pix_blank = 1'b0;
    logic         sck, ws, sd;

    int vectors = 0;
    int errors  = 0;

    always #2.5 mclk = ~mclk;

    vid_i2s_serializer #(.COMP_W(COMP_W), .DIV(DIV), .SYNC_STAGES(2)) i_vid_i2s_serializer (
        .mclk_i      (mclk),
        .rst_i       (rst),
        .cts_i       (cts),
        .pix_valid_i (pix_valid),
        .pix_ready_o (pix_ready),
        .pix_data_i  (pix_data),
        .pix_sof_i   (pix_sof),
        .pix_blank_i (pix_blank),
        .sck_o       (sck),
        .ws_o        (ws),
        .sd_o        (sd)
    );

    // expected words: {slot, data}
    logic [W:0] exp_q[$];
    bit   armed     = 1'b0;
    bit   exp_slot  = 1'b0;
    int   streamed  = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // receiver model
    int         rises   = 0;
    int         rx_n    = 0;
    logic [W-1:0] rx_word = '0;
    logic [W-1:0] rx_ws   = '0;
    int         since   = 0;

    always @(posedge mclk) since++;

    always @(posedge sck) begin
        rises++;
        if (rx_n != 0) check(since == DIV, "R1 sck period", since, DIV);
        since = 0;
        rx_word = {rx_word[W-2:0], sd};
        rx_ws   = {rx_ws[W-2:0], ws};
        rx_n++;
        if (rx_n == W) begin
            rx_n = 0;
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected word", int'(rx_word), -1);
            end else begin
                logic [W:0] e;
                e = exp_q.pop_front();
                check(rx_word == e[W-1:0], "R2 word data", int'(rx_word), int'(e[W-1:0]));
                check(rx_ws == {W{e[W]}}, "R3 ws slot", int'(rx_ws), int'({W{e[W]}}));
            end
        end
    end

    // R4 stability while sck high
    logic prev_sck = 1'b0, prev_sd = 1'b0, prev_ws = 1'b0;
    always @(negedge mclk) begin
        if (!rst && sck && prev_sck)
            check(sd == prev_sd && ws == prev_ws, "R4 stable while high",
                  int'({sd, ws}), int'({prev_sd, prev_ws}));
        prev_sck = sck; prev_sd = sd; prev_ws = ws;
    end

    task automatic send(input logic [W-1:0] d, input bit sof, input bit blank);
        @(negedge mclk);
        pix_valid = 1'b1; pix_data = d; pix_sof = sof; pix_blank = blank;
        #1;
        if (blank) check(pix_ready == 1'b1, "R8 ready during blank", int'(pix_ready), 1);
        while (!pix_ready) begin
            @(negedge mclk); #1;
        end
        if (!blank) begin
            if (sof) begin
                armed    = cts;
                exp_slot = 1'b0;
            end
            if (armed) begin
                exp_q.push_back({exp_slot, d});
                exp_slot = ~exp_slot;
                streamed++;
            end
        end
        @(posedge mclk); #1;
        pix_valid = 1'b0; pix_sof = 1'b0; pix_blank = 1'b0;
    endtask

    task automatic blanks(input int n);
        for (int i = 0; i < n; i++) send('0, 1'b0, 1'b1);
    endtask

    task automatic set_cts(input bit v);
        @(negedge mclk); cts = v;
        repeat (4) @(negedge mclk);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge mclk);
                check(1'b0, "watchdog", 0, 1);
                finish_run();
            end
        join_none

        repeat (5) @(posedge mclk);
        @(negedge mclk); rst = 1'b0;
        @(negedge mclk);
        // R9 reset state
        check(!sck && !ws && !sd, "R9 outputs low after reset", int'({sck, ws, sd}), 0);
        check(pix_ready == 1'b1, "R9 ready after reset", int'(pix_ready), 1);

        // R6: frame refused with clear-to-send low
        set_cts(1'b0);
        send(6'h15, 1'b1, 1'b0);
        for (int i = 0; i < 9; i++) send(W'(i + 3), 1'b0, 1'b0);
        blanks(30);
        check(rises == 0, "R6 no edges without cts", rises, 0);

        // R2/R3/R5: sweep every code, lines separated by long blanking
        set_cts(1'b1);
        for (int ln = 0; ln < 8; ln++) begin
            for (int px = 0; px < 8; px++)
                send(W'(ln * 8 + px), (ln == 0 && px == 0), 1'b0);
            blanks(60);
            begin
                int snap;
                snap = rises;
                blanks(30);
                check(rises == snap, "R5 quiet during blanking", rises, snap);
            end
        end

        // R3: odd frame, then a new frame must restart in the left slot
        send(6'h2A, 1'b1, 1'b0);
        for (int i = 0; i < 4; i++) send(W'(6'h30 + i), 1'b0, 1'b0);
        // R7: next frame, clear-to-send falls midway, frame still completes
        send(6'h01, 1'b1, 1'b0);
        send(6'h3F, 1'b0, 1'b0);
        @(negedge mclk); cts = 1'b0;
        for (int i = 0; i < 5; i++) send(W'(6'h0C + i), 1'b0, 1'b0);
        blanks(20);
        // R7: frame started while clear-to-send low is dropped
        send(6'h11, 1'b1, 1'b0);
        for (int i = 0; i < 4; i++) send(W'(6'h22 + i), 1'b0, 1'b0);
        blanks(40);
        check(exp_q.size() == 0, "R7 stale frame drained", exp_q.size(), 0);

        // R6: re-armed frame
        set_cts(1'b1);
        send(6'h3C, 1'b1, 1'b0);
        send(6'h03, 1'b0, 1'b0);
        blanks(3);
        send(6'h24, 1'b0, 1'b0);
        blanks(60);

        check(exp_q.size() == 0, "R8 all pixels delivered", exp_q.size(), 0);
        check(rises == streamed * W, "R5 edge count", rises, streamed * W);
        check(rx_n == 0, "R2 whole words only", rx_n, 0);
        finish_run();
    end
endmodule